// File: doc/BRIEF.md
# Complementary PWM Generator with Buffered Duty Transfer

The block produces a pair of complementary PWM outputs from two triangle counters that share one period register. The leading counter starts at a fixed offset and the trailing counter starts at zero, so the trailing triangle runs the same shape a fixed number of cycles later. That lag is the only separation between the two outputs. One compare register sets the duty. The normal-phase output uses the compare register against the leading counter. The counter-phase output uses it against the trailing counter.

Software never writes the compare register directly. It writes a buffer register. Transfer logic copies the buffer into the compare register on an event chosen by a 2-bit mode field. An override applies when the buffered duty is out of range. While the buffer holds a value at or above the period, copies happen only at the trailing counter's underflow. The override stays in force until a usable value between one and the period minus one has been taken at such an underflow. Register writes arrive through a small address/data port. A single enable starts and stops both counters.

Top module: `cpwm_duty_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its start state. Mode becomes 00, both polarity bits become 1, the buffer and compare registers become 0 and the override flag clears. Both outputs read 0 after that edge.
- R2: When `run_en` is low, the leading counter sits at `OFFSET` counting up and the trailing counter sits at 0 counting up. While `run_en` is high, each counter steps by one per cycle. It turns downward on the cycle after it equals the period, and it turns upward on the cycle after it reads 0 while counting down. That down-count cycle at 0 is the counter's underflow event.
- R3: Mode 00 copies the buffer into the compare register at the trailing counter's underflow. Mode 01 copies at the leading counter's underflow. Mode 10 copies at either underflow.
- R4: Mode 11 copies the buffer at the cycle in which the leading counter equals the period while counting up.
- R5: While the buffer is greater than or equal to the period, copies occur only at trailing-counter underflows, whatever the mode. The override flag is set in that cycle.
- R6: Once the override flag is set, it stays set until a trailing-counter underflow copies a buffer value in the range 1 to period−1. A buffer value of 0 keeps the override. After the flag clears, copies follow the mode field again.
- R7: The normal phase is active in the cycle after compare > leading counter. The counter phase is active in the cycle after compare ≤ trailing counter.
- R8: Control bit 2 sets the active level of `pwm_norm` and control bit 3 sets the active level of `pwm_cntr` (1 = active high). The outputs are registered. While `run_en` is low, each output is at its inactive level one cycle later.
- R9: Address 0 writes the period, but only while `run_en` is low. A write there while running is dropped. Address 1 writes the buffer. Address 2 writes control, with the mode in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 buffer, 2 control |
| wr_data | input | CW | Write data |
| pwm_norm | output | 1 | Normal-phase output |
| pwm_cntr | output | 1 | Counter-phase output |

## Verification
A bad counter step or turn point moves both pulse edges. That error appears at the outputs within one triangle, because every edge is timed against a counter. A compare copy taken on the wrong event shifts the pulse width for a whole half period. It becomes visible at the next crossing of the compare value, at most one period later. A stuck override flag shows up as copies that keep landing on trailing underflows after an in-range value was taken. The bench therefore writes each duty value from zero to above the period under every mode and polarity. It then compares both outputs on every cycle.

// File: rtl/cpwm_pkg.sv
// Shared definitions for the complementary PWM block.
// Assumes: register addresses are 2 bits wide.
package cpwm_pkg;
    typedef enum logic [1:0] {
        XF_TRAIL_UNF = 2'b00,
        XF_LEAD_UNF  = 2'b01,
        XF_BOTH_UNF  = 2'b10,
        XF_LEAD_TOP  = 2'b11
    } xfer_mode_e;

    localparam logic [1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [1:0] ADDR_BUFFER  = 2'd1;
    localparam logic [1:0] ADDR_CONTROL = 2'd2;

    localparam int CTRL_POL_NORM = 2;
    localparam int CTRL_POL_CNTR = 3;
endpackage

// File: rtl/cpwm_tri_counter.sv
// Up/down triangle counter between 0 and the period value.
// Reloads START counting up while stopped; flags the top match and the
// down-count underflow at zero. Assumes START <= period.
module cpwm_tri_counter #(
    parameter int CW    = 16,
    parameter int START = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          at_top,
    output logic          underflow
);
    localparam logic [CW-1:0] START_V = CW'(START);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic up;

    // Event decode from current count and direction.
    assign at_top    = run && up && (cnt == period);
    assign underflow = run && !up && (cnt == '0);

    // Triangle stepping, reload while stopped or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= START_V;
            up  <= 1'b1;
        end else if (up) begin
            if (cnt >= period) begin
                up  <= 1'b0;
                cnt <= cnt - ONE;
            end else begin
                cnt <= cnt + ONE;
            end
        end else if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= ONE;
        end else begin
            cnt <= cnt - ONE;
        end
    end

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && run && $past(run)) |->
        ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

    assert_within_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && run && $past(run)) |-> (cnt <= period));
endmodule

// File: rtl/cpwm_xfer_ctrl.sv
// Buffer-to-compare transfer control with out-of-range override.
// Chooses the copy event from the mode, or forces trailing-underflow copies
// while the override flag is set or the buffer is at/above the period.
module cpwm_xfer_ctrl #(
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cpwm_pkg::xfer_mode_e mode,
    input  logic [CW-1:0]       buf_val,
    input  logic [CW-1:0]       period,
    input  logic                lead_top,
    input  logic                lead_unf,
    input  logic                trail_unf,
    output logic [CW-1:0]       cmp,
    output logic                forced
);
    import cpwm_pkg::*;

    logic over, mode_evt, do_xfer;

    // Out-of-range detection on the buffered duty.
    assign over = (buf_val >= period);

    // Event selected by the mode field.
    always_comb begin
        unique case (mode)
            XF_TRAIL_UNF: mode_evt = trail_unf;
            XF_LEAD_UNF:  mode_evt = lead_unf;
            XF_BOTH_UNF:  mode_evt = lead_unf | trail_unf;
            default:      mode_evt = lead_top;
        endcase
    end

    // Override replaces the mode event with the trailing underflow.
    assign do_xfer = (forced || over) ? trail_unf : mode_evt;

    // Compare register copy.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp <= '0;
        else if (do_xfer) cmp <= buf_val;
    end

    // Sticky override flag: set on out-of-range, cleared by an in-range underflow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                             forced <= 1'b0;
        else if (over)                          forced <= 1'b1;
        else if (trail_unf && buf_val != '0)    forced <= 1'b0;
    end

    assert_forced_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (forced && !trail_unf) |=> $stable(cmp));

    assert_flag_clear_at_unf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(forced)) |-> $past(trail_unf));

    assert_flag_set_on_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> forced);
endmodule

// File: rtl/cpwm_out_stage.sv
// Registered complementary output pair with per-output polarity.
// Channel 0 compares against the leading counter (active while cmp > count);
// channel 1 against the trailing counter (active while cmp <= count).
module cpwm_out_stage #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] lead_cnt,
    input  logic [CW-1:0] trail_cnt,
    input  logic [1:0]    pol,
    output logic [1:0]    pwm
);
    localparam int NCH = 2;

    logic [NCH-1:0] active;

    // Phase conditions: normal is compare-above, counter-phase is its complement.
    assign active[0] = (cmp > lead_cnt);
    assign active[1] = !(cmp > trail_cnt);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Output register with polarity; inactive level while stopped.
        always_ff @(posedge clk) begin
            if (!rst_n)   pwm[ch] <= 1'b0;
            else if (run) pwm[ch] <= active[ch] ? pol[ch] : !pol[ch];
            else          pwm[ch] <= !pol[ch];
        end
    end

    assert_idle_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> (pwm == ~$past(pol)));
endmodule

// File: rtl/cpwm_duty_top.sv
// Complementary PWM generator with buffered duty register.
// Holds the period, buffer and control registers, runs the two offset
// triangle counters and the transfer logic. Assumes OFFSET < period.
module cpwm_duty_top #(
    parameter int CW         = 16,
    parameter int OFFSET     = 4,
    parameter int PERIOD_RST = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pwm_norm,
    output logic          pwm_cntr
);
    import cpwm_pkg::*;

    logic [CW-1:0] period_q, buf_q, cmp, lead_cnt, trail_cnt;
    xfer_mode_e    mode_q;
    logic [1:0]    pol_q, pwm;
    logic          lead_top, lead_unf, trail_top, trail_unf, forced;

    // Register write port; period only accepted while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= CW'(PERIOD_RST);
            buf_q    <= '0;
            mode_q   <= XF_TRAIL_UNF;
            pol_q    <= 2'b11;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD:  if (!run_en) period_q <= wr_data;
                ADDR_BUFFER:  buf_q <= wr_data;
                ADDR_CONTROL: begin
                    mode_q <= xfer_mode_e'(wr_data[1:0]);
                    pol_q  <= {wr_data[CTRL_POL_CNTR], wr_data[CTRL_POL_NORM]};
                end
                default: ;
            endcase
        end
    end

    cpwm_tri_counter #(.CW(CW), .START(OFFSET)) u_lead (
        .clk(clk), .rst_n(rst_n), .run(run_en), .period(period_q),
        .cnt(lead_cnt), .at_top(lead_top), .underflow(lead_unf));

    cpwm_tri_counter #(.CW(CW), .START(0)) u_trail (
        .clk(clk), .rst_n(rst_n), .run(run_en), .period(period_q),
        .cnt(trail_cnt), .at_top(trail_top), .underflow(trail_unf));

    cpwm_xfer_ctrl #(.CW(CW)) u_xfer (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .buf_val(buf_q),
        .period(period_q), .lead_top(lead_top), .lead_unf(lead_unf),
        .trail_unf(trail_unf), .cmp(cmp), .forced(forced));

    cpwm_out_stage #(.CW(CW)) u_out (
        .clk(clk), .rst_n(rst_n), .run(run_en), .cmp(cmp),
        .lead_cnt(lead_cnt), .trail_cnt(trail_cnt), .pol(pol_q), .pwm(pwm));

    assign pwm_norm = pwm[0];
    assign pwm_cntr = pwm[1];

    assert_period_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && run_en && $past(run_en)) |-> $stable(period_q));

    assert_lag_events_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_unf && trail_unf) && !(lead_top && trail_top));
endmodule

// File: tb/sim_cpwm_duty_top.sv
// Sweep bench: every mode, polarity, duty value 0..P+1 and several periods,
// with outputs predicted cycle by cycle from the requirements.
module sim_cpwm_duty_top;
    localparam int CW  = 8;
    localparam int OFF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          pwm_norm, pwm_cntr;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    cpwm_duty_top #(.CW(CW), .OFFSET(OFF), .PERIOD_RST(20)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_norm(pwm_norm), .pwm_cntr(pwm_cntr));

    // Expected state derived from R1..R9.
    int  e_per, e_buf, e_mode, e_cmp;
    int  e_a, e_b;
    bit  e_upa, e_upb, e_force, e_pn, e_pc, e_on, e_oc;

    always @(posedge clk) begin
        bit at, au, bu, over, evt, x;
        if (!rst_n) begin   // R1
            e_per = 20; e_buf = 0; e_mode = 0; e_cmp = 0; e_force = 0;
            e_pn = 1; e_pc = 1; e_on = 0; e_oc = 0;
            e_a = OFF; e_upa = 1; e_b = 0; e_upb = 1;
        end else begin
            at = run_en && e_upa && e_a == e_per;
            au = run_en && !e_upa && e_a == 0;
            bu = run_en && !e_upb && e_b == 0;
            over = e_buf >= e_per;
            case (e_mode)
                0: evt = bu;
                1: evt = au;
                2: evt = au || bu;
                default: evt = at;
            endcase
            x = (e_force || over) ? bu : evt;          // R5 R6
            // R7 R8: outputs from the values before this edge
            if (run_en) begin
                e_on = (e_cmp > e_a) ? e_pn : !e_pn;
                e_oc = (e_cmp <= e_b) ? e_pc : !e_pc;
            end else begin
                e_on = !e_pn; e_oc = !e_pc;
            end
            if (x) e_cmp = e_buf;
            if (over) e_force = 1;
            else if (bu && e_buf != 0) e_force = 0;
            // R2 triangles
            if (!run_en) begin
                e_a = OFF; e_upa = 1; e_b = 0; e_upb = 1;
            end else begin
                if (e_upa) begin if (e_a >= e_per) begin e_upa = 0; e_a--; end else e_a++; end
                else if (e_a == 0) begin e_upa = 1; e_a = 1; end else e_a--;
                if (e_upb) begin if (e_b >= e_per) begin e_upb = 0; e_b--; end else e_b++; end
                else if (e_b == 0) begin e_upb = 1; e_b = 1; end else e_b--;
            end
            // R9 register map
            if (wr_en) begin
                if (wr_addr == 2'd0 && !run_en) e_per = int'(wr_data);
                else if (wr_addr == 2'd1) e_buf = int'(wr_data);
                else if (wr_addr == 2'd2) begin
                    e_mode = int'(wr_data[1:0]);
                    e_pn = wr_data[2]; e_pc = wr_data[3];
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle output comparison, away from the rising edge.
    always @(negedge clk) begin
        if (checking) begin
            chk(cur_req, "pwm_norm", int'(pwm_norm), int'(e_on));
            chk(cur_req, "pwm_cntr", int'(pwm_cntr), int'(e_oc));
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs inactive low after reset
        chk("R1", "pwm_norm after reset", int'(pwm_norm), 0);
        chk("R1", "pwm_cntr after reset", int'(pwm_cntr), 0);
        checking = 1'b1;

        for (int p = 5; p <= 7; p++) begin
            run_en = 1'b0;
            cur_req = "R9";
            wr(2'd0, p);                       // R9: period accepted while stopped
            for (int m = 0; m < 4; m++) begin
                for (int pol = 0; pol < 4; pol++) begin
                    cur_req = "R8";
                    wr(2'd2, (pol << 2) | m);
                    run_en = 1'b1;
                    for (int dv = 0; dv <= p + 1; dv++) begin
                        // R3 R4 by mode, R5 when out of range, R6 on the way back in range
                        if (dv >= p)      cur_req = "R5";
                        else if (dv == 0) cur_req = "R6";
                        else if (m == 3)  cur_req = "R4";
                        else              cur_req = "R3";
                        wr(2'd1, dv);
                        idle(4 * p);
                    end
                    cur_req = "R6";
                    wr(2'd1, 1);
                    idle(4 * p);
                    cur_req = "R7";
                    wr(2'd1, p / 2);
                    idle(4 * p);
                    cur_req = "R8";
                    run_en = 1'b0;
                    idle(2);
                end
            end
        end

        // R9: period write while running is dropped, triangle keeps old length
        wr(2'd2, 12);
        wr(2'd1, 3);
        run_en = 1'b1;
        idle(10);
        cur_req = "R9";
        wr(2'd0, 9);
        idle(40);
        run_en = 1'b0;
        idle(3);
        cur_req = "R2";
        run_en = 1'b1;
        idle(40);

        // R1: reset in mid-run returns outputs to inactive low
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        run_en = 1'b0;
        checking = 1'b0;
        @(negedge clk);
        chk("R1", "pwm_norm after mid-run reset", int'(pwm_norm), 0);
        chk("R1", "pwm_cntr after mid-run reset", int'(pwm_cntr), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule